// File: doc/BRIEF.md
# I2C Bus Condition Output Controller

This block sits between the serial shifter of a two-wire interface and the open-drain pad drivers of its clock and data lines. Software writes request bits to ask for a start, a repeated start or a stop condition. A sequencer then steps the lines through the phases of that condition, one phase per prescaler tick. When a sequence ends, its request bit clears itself. A source-select bit decides what drives the lines. With the bit at 0, the pads follow the shifter. With the bit at 1, they carry the generated condition levels.

Two overrides act on the data path. The first replaces shifted data with a programmed acknowledge level. The second holds the clock low to stretch it. Data coming from the shifter or from the acknowledge override can be delayed. The delay is a programmable number of prescaler ticks and gives extra data hold time after the clock falls. Both outputs are pull-down enables: 1 drives the line low and 0 releases it.

Sequencer states: `ST_IDLE` holds the parked levels. `ST_START_A` releases the clock and pulls data low; `ST_START_B` then pulls both. `ST_RST_A`, `ST_RST_B`, `ST_RST_C` and `ST_RST_D` pass through clock low with data released, then both released, then data low, then both low. `ST_STOP_A` pulls the clock and keeps data as parked. `ST_STOP_B` pulls both, `ST_STOP_C` releases the clock, and `ST_STOP_D` releases data. Every transition is taken on a prescaler tick. `ST_IDLE` goes to the first state of the served condition only while generation is selected. Each state goes to the next one in its chain. The last state of each chain goes back to `ST_IDLE`, stores its levels as the new parked levels and clears the served request.

Top module: `i2c_cond_out`

## Requirements
- R1: After reset all request bits read 0 and generation is deselected. With both serial inputs high, both outputs are 0 (released).
- R2: With the select bit (control register, address 0, bit 3) at 0, `scl_pull` equals the inverse of `ser_scl_in`. With a delay code of 0 and the acknowledge override off, `sda_pull` equals the inverse of `ser_sda_in`. Pending requests are not served and stay set. A write to address 0 loads bits 2:0 as the request bits (bit 0 start, bit 1 restart, bit 2 stop) and bit 3 as the select bit. Writing 0 cancels a pending request.
- R3: From released parked lines, a start drives {scl_pull,sda_pull} = 01 and then 11. Each step comes on a prescaler tick, and the steps are exactly one tick period apart.
- R4: From parked 11, a stop drives 01 and then 00, one tick apart. From parked 00, a stop drives 10, 11, 01, 00.
- R5: From parked 11, a restart drives 10, 00, 01, 11.
- R6: A request bit, read on `req_pending` with the same bit order, returns to 0 once its sequence ends. The other requests stay set.
- R7: When several requests are pending, stop is served first, then restart, then start, with one sequence at a time.
- R8: The mode register is at address 1, with bit 0 the acknowledge level, bit 1 the acknowledge enable, bit 2 the clock hold and bits 6:4 the delay code. With the acknowledge enable at 1, the data path carries the acknowledge level instead of `ser_sda_in`: level 0 pulls SDA low and level 1 releases it.
- R9: With the clock hold bit at 1, `scl_pull` is 1 in both serial and generated modes. Clearing the bit restores the previous source.
- R10: With delay code n from 1 to 7, a change on the data path reaches `sda_pull` after n or n+1 tick periods, depending on the tick phase. Code 0 passes the change through in the same cycle.
- R11: In generated mode, SDA changes while SCL stays released only as the start edge or the stop edge of a requested condition. Each start, restart or stop sequence makes exactly one such change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 mode |
| reg_wdata | input | 8 | Write data |
| brg_tick | input | 1 | One-cycle pulse from the baud prescaler |
| ser_scl_in | input | 1 | Clock level from the shifter (1 = high) |
| ser_sda_in | input | 1 | Data level from the shifter (1 = high) |
| scl_pull | output | 1 | Clock pad pull-down enable |
| sda_pull | output | 1 | Data pad pull-down enable |
| req_pending | output | 3 | Pending requests: bit 0 start, bit 1 restart, bit 2 stop |

## Verification
Each condition is requested from both parked line states, released and low. The recorded edge sequences are compared, so a swapped phase, a missing phase or a wrong parked level each show up as a different trace. All three requests are then written at once, and the order in which the request bits clear tells the priority apart from simple bit order. The delay is measured in cycles at several tick phases for codes 0, 1, 3 and 7, which separates an n-tick delay from an n+1-tick delay and from an off-by-one stage select. The acknowledge and clock-hold overrides are set against serial input levels that would otherwise give the opposite output.

// File: rtl/i2c_cond_pkg.sv
`timescale 1ns/1ps
package i2c_cond_pkg;

    localparam int NUM_REQ     = 3;
    localparam int REQ_START   = 0;
    localparam int REQ_RESTART = 1;
    localparam int REQ_STOP    = 2;

    localparam int CODE_W      = 3;

    // control register (address 0)
    localparam int BIT_GEN     = 3;
    // mode register (address 1)
    localparam int BIT_ACKV    = 0;
    localparam int BIT_ACKE    = 1;
    localparam int BIT_HOLD    = 2;
    localparam int BIT_DLY_LO  = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_A, ST_START_B,
        ST_RST_A, ST_RST_B, ST_RST_C, ST_RST_D,
        ST_STOP_A, ST_STOP_B, ST_STOP_C, ST_STOP_D
    } cond_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] dly_code;
        logic              scl_hold;
        logic              ack_en;
        logic              ack_val;
    } line_cfg_t;

endpackage

// File: rtl/i2c_cond_regs.sv
`timescale 1ns/1ps
module i2c_cond_regs
    import i2c_cond_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [DW-1:0]      wr_data,
    input  logic [NUM_REQ-1:0] done_i,
    output logic [NUM_REQ-1:0] req_o,
    output logic               gen_sel_o,
    output line_cfg_t          cfg_o
);

    logic [NUM_REQ-1:0] req_q;
    logic               gen_q;
    line_cfg_t          cfg_q;
    logic               wr_ctrl;
    logic               wr_mode;

    assign wr_ctrl = wr_en && !wr_addr;
    assign wr_mode = wr_en &&  wr_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            gen_q <= 1'b0;
            cfg_q <= '0;
        end else begin
            req_q <= req_q & ~done_i;
            if (wr_ctrl) begin
                req_q <= wr_data[NUM_REQ-1:0];
                gen_q <= wr_data[BIT_GEN];
            end
            if (wr_mode) begin
                cfg_q.ack_val  <= wr_data[BIT_ACKV];
                cfg_q.ack_en   <= wr_data[BIT_ACKE];
                cfg_q.scl_hold <= wr_data[BIT_HOLD];
                cfg_q.dly_code <= wr_data[BIT_DLY_LO +: CODE_W];
            end
        end
    end

    assign req_o     = req_q;
    assign gen_sel_o = gen_q;
    assign cfg_o     = cfg_q;

    // R6: a finished request is cleared unless software rewrote it
    a_r6_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (|done_i) && !wr_ctrl |=> ((req_q & $past(done_i)) == '0));

endmodule

// File: rtl/i2c_cond_fsm.sv
`timescale 1ns/1ps
module i2c_cond_fsm
    import i2c_cond_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               gen_sel,
    input  logic [NUM_REQ-1:0] req,
    output logic               gen_scl_pull,
    output logic               gen_sda_pull,
    output logic [NUM_REQ-1:0] done
);

    cond_state_e        state_q, state_d;
    logic [NUM_REQ-1:0] serve_q, serve_d;
    logic               park_scl_q, park_sda_q;
    logic               last_phase;

    assign last_phase = (state_q == ST_START_B) || (state_q == ST_RST_D) ||
                        (state_q == ST_STOP_D);
    assign done = (tick && last_phase) ? serve_q : '0;

    // next state
    always_comb begin
        state_d = state_q;
        serve_d = serve_q;
        if (tick) begin
            unique case (state_q)
                ST_IDLE: begin
                    if (gen_sel) begin
                        if (req[REQ_STOP]) begin
                            state_d = ST_STOP_A;
                            serve_d = NUM_REQ'(1) << REQ_STOP;
                        end else if (req[REQ_RESTART]) begin
                            state_d = ST_RST_A;
                            serve_d = NUM_REQ'(1) << REQ_RESTART;
                        end else if (req[REQ_START]) begin
                            state_d = ST_START_A;
                            serve_d = NUM_REQ'(1) << REQ_START;
                        end
                    end
                end
                ST_START_A: state_d = ST_START_B;
                ST_START_B: state_d = ST_IDLE;
                ST_RST_A:   state_d = ST_RST_B;
                ST_RST_B:   state_d = ST_RST_C;
                ST_RST_C:   state_d = ST_RST_D;
                ST_RST_D:   state_d = ST_IDLE;
                ST_STOP_A:  state_d = ST_STOP_B;
                ST_STOP_B:  state_d = ST_STOP_C;
                ST_STOP_C:  state_d = ST_STOP_D;
                ST_STOP_D:  state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            serve_q    <= '0;
            park_scl_q <= 1'b0;
            park_sda_q <= 1'b0;
        end else begin
            state_q <= state_d;
            serve_q <= serve_d;
            if (tick && last_phase) begin
                park_scl_q <= gen_scl_pull;
                park_sda_q <= gen_sda_pull;
            end
        end
    end

    // line levels per state (1 = pull low)
    always_comb begin
        unique case (state_q)
            ST_IDLE:    begin gen_scl_pull = park_scl_q; gen_sda_pull = park_sda_q; end
            ST_START_A: begin gen_scl_pull = 1'b0;       gen_sda_pull = 1'b1;       end
            ST_START_B: begin gen_scl_pull = 1'b1;       gen_sda_pull = 1'b1;       end
            ST_RST_A:   begin gen_scl_pull = 1'b1;       gen_sda_pull = 1'b0;       end
            ST_RST_B:   begin gen_scl_pull = 1'b0;       gen_sda_pull = 1'b0;       end
            ST_RST_C:   begin gen_scl_pull = 1'b0;       gen_sda_pull = 1'b1;       end
            ST_RST_D:   begin gen_scl_pull = 1'b1;       gen_sda_pull = 1'b1;       end
            ST_STOP_A:  begin gen_scl_pull = 1'b1;       gen_sda_pull = park_sda_q; end
            ST_STOP_B:  begin gen_scl_pull = 1'b1;       gen_sda_pull = 1'b1;       end
            ST_STOP_C:  begin gen_scl_pull = 1'b0;       gen_sda_pull = 1'b1;       end
            ST_STOP_D:  begin gen_scl_pull = 1'b0;       gen_sda_pull = 1'b0;       end
            default:    begin gen_scl_pull = 1'b0;       gen_sda_pull = 1'b0;       end
        endcase
    end

    // R3: phases advance only on a prescaler tick
    a_r3_phase_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));

    // R2: nothing is served while generation is deselected
    a_r2_idle_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !gen_sel |=> (state_q == ST_IDLE));

    // R7: stop wins over the other requests
    a_r7_stop_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && tick && gen_sel && req[REQ_STOP] |=> (state_q == ST_STOP_A));

    // R7: at most one request completes at a time
    a_r7_one_done: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    // R11: data moves under a released clock only at a start or stop edge
    a_r11_sda_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_sda_pull != $past(gen_sda_pull)) && !gen_scl_pull && !$past(gen_scl_pull)
        |-> (state_q == ST_START_A) || (state_q == ST_RST_C) || (state_q == ST_STOP_D));

endmodule

// File: rtl/i2c_sda_delay.sv
`timescale 1ns/1ps
module i2c_sda_delay
    import i2c_cond_pkg::*;
#(
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] code,
    input  logic          d_in,
    output logic          d_out
);

    localparam int STAGES = 1 << CW;

    logic [STAGES-1:0] stage_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    stage_q <= '0;
                else if (tick) stage_q <= {stage_q[STAGES-2:0], d_in};
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)    stage_q <= '0;
                else if (tick) stage_q <= d_in;
            end
        end
    endgenerate

    assign d_out = (code == '0) ? d_in : stage_q[code];

    // R10: the delay line advances only on prescaler ticks
    a_r10_shift_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(stage_q));

endmodule

// File: rtl/i2c_cond_out.sv
`timescale 1ns/1ps
module i2c_cond_out
    import i2c_cond_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic               reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    input  logic               brg_tick,
    input  logic               ser_scl_in,
    input  logic               ser_sda_in,
    output logic               scl_pull,
    output logic               sda_pull,
    output logic [NUM_REQ-1:0] req_pending
);

    logic [NUM_REQ-1:0] req;
    logic [NUM_REQ-1:0] done;
    logic               gen_sel;
    line_cfg_t          cfg;
    logic               gen_scl_pull, gen_sda_pull;
    logic               data_pull, data_pull_dly;

    i2c_cond_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .done_i    (done),
        .req_o     (req),
        .gen_sel_o (gen_sel),
        .cfg_o     (cfg)
    );

    i2c_cond_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (brg_tick),
        .gen_sel      (gen_sel),
        .req          (req),
        .gen_scl_pull (gen_scl_pull),
        .gen_sda_pull (gen_sda_pull),
        .done         (done)
    );

    assign data_pull = cfg.ack_en ? !cfg.ack_val : !ser_sda_in;

    i2c_sda_delay #(.CW(CODE_W)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (brg_tick),
        .code  (cfg.dly_code),
        .d_in  (data_pull),
        .d_out (data_pull_dly)
    );

    assign sda_pull    = gen_sel ? gen_sda_pull : data_pull_dly;
    assign scl_pull    = cfg.scl_hold || (gen_sel ? gen_scl_pull : !ser_scl_in);
    assign req_pending = req;

endmodule

// File: tb/tb_i2c_cond_out.sv
`timescale 1ns/1ps
module tb_i2c_cond_out;

    localparam int P = 4;   // prescaler tick period in clocks

    logic       clk = 1'b0;
    logic       rst_n;
    logic       reg_we;
    logic       reg_addr;
    logic [7:0] reg_wdata;
    logic       brg_tick;
    logic       ser_scl_in;
    logic       ser_sda_in;
    logic       scl_pull;
    logic       sda_pull;
    logic [2:0] req_pending;

    int nchk  = 0;
    int nfail = 0;
    int cyc   = 0;
    bit finished = 0;

    logic [1:0] log_v [0:15];
    int         log_t [0:15];
    int         log_n = 0;
    int         sda_hi = 0;
    logic [1:0] prev_lv = 2'b00;

    always #4 clk = ~clk;

    i2c_cond_out dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .brg_tick(brg_tick), .ser_scl_in(ser_scl_in),
        .ser_sda_in(ser_sda_in), .scl_pull(scl_pull), .sda_pull(sda_pull),
        .req_pending(req_pending)
    );

    // prescaler tick: one cycle in every P
    initial begin
        int tcnt = 0;
        brg_tick = 1'b0;
        forever begin
            @(negedge clk);
            brg_tick = (tcnt == P-1);
            tcnt = (tcnt + 1) % P;
        end
    end

    // line monitor: records {scl_pull,sda_pull} edges shortly after each clock edge
    always begin
        @(posedge clk);
        cyc = cyc + 1;
        #1;
        if ({scl_pull, sda_pull} != prev_lv) begin
            if (!prev_lv[1] && !scl_pull) sda_hi = sda_hi + 1;
            if (log_n < 16) begin
                log_v[log_n] = {scl_pull, sda_pull};
                log_t[log_n] = cyc;
            end
            log_n = log_n + 1;
            prev_lv = {scl_pull, sda_pull};
        end
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic clr_log();
        log_n = 0;
        sda_hi = 0;
    endtask

    task automatic wait_req(input logic [2:0] exp, output bit ok);
        ok = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (req_pending == exp) begin ok = 1; break; end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(scl_pull == 1'b0, "R1 scl released", int'(scl_pull), 0);
        chk(sda_pull == 1'b0, "R1 sda released", int'(sda_pull), 0);
        chk(req_pending == 3'b000, "R1 no request", int'(req_pending), 0);
    endtask

    task automatic t_serial();
        wr(1'b0, 8'h00);
        @(negedge clk); ser_scl_in = 1'b0; ser_sda_in = 1'b0; #1;
        chk(scl_pull == 1'b1, "R2 scl follows shifter", int'(scl_pull), 1);
        chk(sda_pull == 1'b1, "R2 sda follows shifter", int'(sda_pull), 1);
        @(negedge clk); ser_scl_in = 1'b1; ser_sda_in = 1'b1; #1;
        chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R2 lines released",
            int'({scl_pull, sda_pull}), 0);
        wr(1'b0, 8'h01);
        repeat (40) @(negedge clk);
        chk(req_pending == 3'b001, "R2 request stays pending", int'(req_pending), 1);
        chk(scl_pull == 1'b0 && sda_pull == 1'b0, "R2 no condition driven",
            int'({scl_pull, sda_pull}), 0);
        wr(1'b0, 8'h00);
        chk(req_pending == 3'b000, "R2 request cancelled", int'(req_pending), 0);
    endtask

    task automatic t_ack();
        wr(1'b1, 8'h02);   // ack_en, level 0
        #1;
        chk(sda_pull == 1'b1, "R8 ACK pulls sda", int'(sda_pull), 1);
        wr(1'b1, 8'h03);   // ack_en, level 1
        @(negedge clk); ser_sda_in = 1'b0; #1;
        chk(sda_pull == 1'b0, "R8 NACK releases sda, shifter ignored", int'(sda_pull), 0);
        @(negedge clk); ser_sda_in = 1'b1;
        wr(1'b1, 8'h00);
        #1;
        chk(sda_pull == 1'b0, "R8 back to shifter", int'(sda_pull), 0);
    endtask

    task automatic t_delay();
        int codes [4] = '{0, 1, 3, 7};
        foreach (codes[ci]) begin
            for (int off = 0; off < P; off++) begin
                int n = codes[ci];
                int cnt = 0;
                bit seen = 0;
                wr(1'b1, 8'(n << 4));
                ser_sda_in = 1'b1;
                repeat (40 + off) @(negedge clk);
                ser_sda_in = 1'b0;
                #1;
                if (sda_pull) seen = 1;
                while (!seen && cnt < 100) begin
                    @(posedge clk); cnt++;
                    @(negedge clk);
                    if (sda_pull) seen = 1;
                end
                if (n == 0)
                    chk(seen && cnt == 0, "R10 code 0 immediate", cnt, 0);
                else
                    chk(seen && cnt > n*P && cnt <= (n+1)*P, "R10 delay n or n+1 ticks",
                        cnt, (n+1)*P);
                ser_sda_in = 1'b1;
            end
        end
        wr(1'b1, 8'h00);
        repeat (40) @(negedge clk);
    endtask

    task automatic t_start();
        bit ok;
        clr_log();
        wr(1'b0, 8'h09);
        wait_req(3'b000, ok);
        chk(ok, "R6 start request cleared", int'(req_pending), 0);
        chk(log_n == 2, "R3 start edge count", log_n, 2);
        chk(log_v[0] == 2'b01, "R3 start phase 1", int'(log_v[0]), 1);
        chk(log_v[1] == 2'b11, "R3 start phase 2", int'(log_v[1]), 3);
        chk(log_t[1] - log_t[0] == P, "R3 phase lasts one tick", log_t[1] - log_t[0], P);
        chk(sda_hi == 1, "R11 one edge under high scl", sda_hi, 1);
    endtask

    task automatic t_stop_from_low();
        bit ok;
        clr_log();
        wr(1'b0, 8'h0C);
        wait_req(3'b000, ok);
        chk(ok, "R6 stop request cleared", int'(req_pending), 0);
        chk(log_n == 2, "R4 stop edge count", log_n, 2);
        chk(log_v[0] == 2'b01 && log_v[1] == 2'b00, "R4 stop phases",
            int'({log_v[0], log_v[1]}), 4);
        chk(sda_hi == 1, "R11 stop edge", sda_hi, 1);
    endtask

    task automatic t_restart();
        bit ok;
        t_start();
        clr_log();
        wr(1'b0, 8'h0A);
        wait_req(3'b000, ok);
        chk(ok, "R6 restart request cleared", int'(req_pending), 0);
        chk(log_n == 4, "R5 restart edge count", log_n, 4);
        chk(log_v[0] == 2'b10 && log_v[1] == 2'b00 && log_v[2] == 2'b01 && log_v[3] == 2'b11,
            "R5 restart phases", int'({log_v[0], log_v[1], log_v[2], log_v[3]}), 8'b10000111);
        chk(sda_hi == 1, "R11 restart edge", sda_hi, 1);
        t_stop_from_low();
    endtask

    task automatic t_priority();
        bit ok;
        clr_log();
        wr(1'b0, 8'h0F);
        wait_req(3'b011, ok);
        chk(ok, "R7 stop served first", int'(req_pending), 3);
        chk(log_n == 4 && log_v[0] == 2'b10 && log_v[3] == 2'b00,
            "R4 stop from released lines", int'({log_v[0], log_v[3]}), 8);
        clr_log();
        wait_req(3'b001, ok);
        chk(ok, "R7 restart served second", int'(req_pending), 1);
        chk(log_n == 4 && log_v[3] == 2'b11, "R7 restart trace", int'(log_v[3]), 3);
        clr_log();
        wait_req(3'b000, ok);
        chk(ok, "R7 start served last", int'(req_pending), 0);
        chk(log_n == 2 && log_v[0] == 2'b01, "R7 start trace", log_n, 2);
    endtask

    task automatic t_hold();
        bit ok;
        wr(1'b0, 8'h0C);
        wait_req(3'b000, ok);
        @(negedge clk);
        chk(scl_pull == 1'b0, "R9 parked released", int'(scl_pull), 0);
        wr(1'b1, 8'h04);
        #1;
        chk(scl_pull == 1'b1, "R9 hold in generated mode", int'(scl_pull), 1);
        wr(1'b0, 8'h00);
        #1;
        chk(scl_pull == 1'b1, "R9 hold in serial mode", int'(scl_pull), 1);
        wr(1'b1, 8'h00);
        #1;
        chk(scl_pull == 1'b0, "R9 hold cleared", int'(scl_pull), 0);
    endtask

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 1'b0; reg_wdata = '0;
        ser_scl_in = 1'b1; ser_sda_in = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_serial();
        t_ack();
        t_delay();
        t_start();
        t_stop_from_low();
        t_restart();
        t_priority();
        t_hold();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

endmodule